// File: doc/BRIEF.md
# Key-Guarded Flash Program/Erase Controller

This block is the register front end for a small embedded flash array. Software reaches it over a plain 32-bit register bus. The bus carries an address, a read strobe, a write strobe and write data, and read data returns one cycle after the read. The upper half of the address space maps the flash cells as 16-bit halfwords. The lower half holds four registers: a key register, a status register, a control register and an address register.

After reset the controller is locked. Software unlocks it by writing two fixed keys in a row. It can then select halfword programming, page erase or mass erase. For programming, software writes halfwords into the flash region. For an erase, it sets a start bit, and a busy flag stays up for the length of the operation. An end-of-operation flag and two error flags report the result, and software clears them by writing 1 to them.

A key sequence with a wrong value or in the wrong order locks the controller for good until the next reset. The array inside the block is a behavioural model with fixed operation times, so every result can be read back over the bus.

Top module: `flc_regs`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x80: lock bit 7 is set and all other bits are 0. The status register (offset 0x0C) reads 0, and every flash halfword reads 0xFFFF. An address with bit 7 set selects the flash region, and address bits [6:1] give the halfword index.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) in two consecutive key writes clears lock bit 7.
- R3: A wrong value in either key write, or the second key written first, sends the controller to a permanent locked state. In that state no later key writes and no lock writes unlock it; only reset leaves it.
- R4: While the controller is locked, writes to the control and address registers (offset 0x14) do not change them. Writing 1 to control bit 7 while unlocked locks the controller again, and the same write loads bits 0, 1 and 2.
- R5: While unlocked, a single control write that sets start (bit 6) together with page erase (bit 1) erases the whole page of 16 halfwords. The page is the one that holds the byte address in the address register, taken from address-register bits [6:5]. Status bit 0 (busy) is 1 for 16 cycles, and start reads back as 1 until busy falls.
- R6: Start with mass erase (bit 2) erases all 64 halfwords, and busy is 1 for 64 cycles. Mass erase wins when bits 1 and 2 are both set.
- R7: With program select (control bit 0) set, a write to the flash region stores wdata[15:0] in an erased cell. Busy is then 1 for 5 cycles, and end of operation (status bit 5) is set as busy falls.
- R8: Programming a cell that does not read 0xFFFF leaves the cell unchanged. Busy is then 1 for 2 cycles, status bit 2 is set as busy falls, and end of operation is not set.
- R9: While locked, a flash-region write, or a control write with start and an erase bit, sets status bit 4 and changes no cell.
- R10: Writing 1 to status bits 2, 4 or 5 clears them. A flag being set in the same cycle wins over the clear.
- R11: While busy, flash reads return 0, and writes to flash, control and address are ignored.
- R12: Read data appears one cycle after the read strobe and is 0 in cycles with no read. The key register and offsets 0x00, 0x1C and 0x20 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; MSB selects the flash region |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |

## Verification
Most wrong internal state in this block reaches the bus as soon as software reads the status or control register. A stuck key state shows up in lock bit 7 on the next control read. A busy window that is too long or too short shifts the cycle at which busy falls and the end-of-operation flag appears in a status poll. A wrong page decode, or a cell check that fails, only shows when the affected halfwords are read back after busy drops. The bench therefore reads flash cells both inside and outside each erased page, and it polls status every cycle during operations.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [31:0] OFS_KEY  = 32'h04;
  localparam logic [31:0] OFS_STAT = 32'h0C;
  localparam logic [31:0] OFS_CTRL = 32'h10;
  localparam logic [31:0] OFS_ADDR = 32'h14;

  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam int C_PG   = 0;
  localparam int C_PER  = 1;
  localparam int C_MER  = 2;
  localparam int C_STRT = 6;
  localparam int C_LOCK = 7;

  localparam int S_PGERR = 2;
  localparam int S_LKERR = 4;
  localparam int S_EOP   = 5;

  typedef enum logic [1:0] {KG_OPEN, KG_WAIT1, KG_WAIT2, KG_DEAD} kg_state_t;
  typedef enum logic [2:0] {EN_IDLE, EN_ERASE, EN_PRD, EN_PCHK, EN_PWAIT} en_state_t;
endpackage

// File: rtl/flc_key_guard.sv
module flc_key_guard
  import flc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        locked,
  output logic        dead
);
  kg_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= KG_WAIT1;
    end else if (key_wr) begin
      case (st)
        KG_WAIT1: st <= (key_val == KEY_FIRST)  ? KG_WAIT2 : KG_DEAD;
        KG_WAIT2: st <= (key_val == KEY_SECOND) ? KG_OPEN  : KG_DEAD;
        default:  st <= st;
      endcase
    end else if (relock && st != KG_DEAD) begin
      st <= KG_WAIT1;
    end
  end

  assign locked = (st != KG_OPEN);
  assign dead   = (st == KG_DEAD);
endmodule

// File: rtl/flc_store.sv
module flc_store #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [15:0]      wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [15:0]      rdata
);
  logic [15:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flc_op_engine.sv
module flc_op_engine
  import flc_pkg::*;
#(
  parameter int PAGES     = 4,
  parameter int PAGE_HW   = 16,
  parameter int PROG_WAIT = 3
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     start_erase,
  input  logic                                     erase_all,
  input  logic [$clog2(PAGES)-1:0]                 page_sel,
  input  logic                                     start_prog,
  input  logic [$clog2(PAGES)+$clog2(PAGE_HW)-1:0] prog_idx,
  input  logic [15:0]                              prog_data,
  input  logic [15:0]                              mem_q,
  output logic                                     busy,
  output logic                                     mem_we,
  output logic [$clog2(PAGES)+$clog2(PAGE_HW)-1:0] mem_waddr,
  output logic [15:0]                              mem_wdata,
  output logic [$clog2(PAGES)+$clog2(PAGE_HW)-1:0] mem_raddr,
  output logic                                     done,
  output logic                                     prog_fail
);
  localparam int HW_W  = $clog2(PAGE_HW);
  localparam int PG_W  = $clog2(PAGES);
  localparam int IDX_W = HW_W + PG_W;
  localparam int CNT_W = $clog2(PROG_WAIT + 1);

  en_state_t        st;
  logic [IDX_W-1:0] ptr, last, pidx;
  logic [15:0]      pdata;
  logic [CNT_W-1:0] cnt;
  logic             cell_blank;

  assign cell_blank = (mem_q == 16'hFFFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= EN_IDLE;
      ptr   <= '0;
      last  <= '0;
      pidx  <= '0;
      pdata <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        EN_IDLE: begin
          if (start_erase) begin
            st   <= EN_ERASE;
            ptr  <= erase_all ? '0 : {page_sel, {HW_W{1'b0}}};
            last <= erase_all ? '1 : {page_sel, {HW_W{1'b1}}};
          end else if (start_prog) begin
            st    <= EN_PRD;
            pidx  <= prog_idx;
            pdata <= prog_data;
          end
        end
        EN_ERASE: begin
          if (ptr == last) st <= EN_IDLE;
          else             ptr <= ptr + 1'b1;
        end
        EN_PRD: st <= EN_PCHK;
        EN_PCHK: begin
          if (cell_blank) begin
            st  <= EN_PWAIT;
            cnt <= CNT_W'(PROG_WAIT - 1);
          end else begin
            st <= EN_IDLE;
          end
        end
        EN_PWAIT: begin
          if (cnt == '0) st <= EN_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  assign busy      = (st != EN_IDLE);
  assign done      = (st == EN_ERASE && ptr == last) || (st == EN_PWAIT && cnt == '0);
  assign prog_fail = (st == EN_PCHK) && !cell_blank;
  assign mem_we    = (st == EN_ERASE) || (st == EN_PCHK && cell_blank);
  assign mem_waddr = (st == EN_ERASE) ? ptr : pidx;
  assign mem_wdata = (st == EN_ERASE) ? 16'hFFFF : pdata;
  assign mem_raddr = pidx;
endmodule

// File: rtl/flc_regs.sv
module flc_regs
  import flc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGES     = 4,
  parameter int PAGE_HW   = 16,
  parameter int PROG_WAIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int HW_W  = $clog2(PAGE_HW);
  localparam int PG_W  = $clog2(PAGES);
  localparam int IDX_W = HW_W + PG_W;
  localparam int DEPTH = PAGES * PAGE_HW;
  localparam int AR_W  = IDX_W + 1;

  logic              is_flash, hit_key, hit_stat, hit_ctrl, hit_addr;
  logic [ADDR_W-2:0] ofs;
  logic              locked, dead, busy, done, prog_fail;
  logic              ctrl_wr_ok, open_ctrl, relock, start_erase, start_prog, lock_err, erase_req;
  logic              pg_q, per_q, mer_q, strt_q, pgerr_q, lkerr_q, eop_q;
  logic [AR_W-1:0]   addr_q;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr, eng_raddr, mem_raddr;
  logic [15:0]       mem_wdata, mem_q;
  logic              rd_flash_q;
  logic [31:0]       reg_q, reg_mux;

  assign is_flash = bus_addr[ADDR_W-1];
  assign ofs      = bus_addr[ADDR_W-2:0];
  assign hit_key  = !is_flash && ofs == OFS_KEY[ADDR_W-2:0];
  assign hit_stat = !is_flash && ofs == OFS_STAT[ADDR_W-2:0];
  assign hit_ctrl = !is_flash && ofs == OFS_CTRL[ADDR_W-2:0];
  assign hit_addr = !is_flash && ofs == OFS_ADDR[ADDR_W-2:0];

  assign erase_req   = bus_wdata[C_STRT] && (bus_wdata[C_PER] || bus_wdata[C_MER]);
  assign ctrl_wr_ok  = bus_we && hit_ctrl && !busy;
  assign relock      = ctrl_wr_ok && bus_wdata[C_LOCK];
  assign open_ctrl   = ctrl_wr_ok && !locked;
  assign start_erase = open_ctrl && erase_req;
  assign start_prog  = bus_we && is_flash && !busy && !locked && pg_q;
  assign lock_err    = bus_we && !busy && locked && (is_flash || (hit_ctrl && erase_req));

  flc_key_guard u_key (
    .clk(clk), .rst(rst), .key_wr(bus_we && hit_key), .key_val(bus_wdata),
    .relock(relock), .locked(locked), .dead(dead)
  );

  flc_op_engine #(.PAGES(PAGES), .PAGE_HW(PAGE_HW), .PROG_WAIT(PROG_WAIT)) u_eng (
    .clk(clk), .rst(rst),
    .start_erase(start_erase), .erase_all(bus_wdata[C_MER]),
    .page_sel(addr_q[AR_W-1 -: PG_W]),
    .start_prog(start_prog), .prog_idx(bus_addr[IDX_W:1]), .prog_data(bus_wdata[15:0]),
    .mem_q(mem_q), .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(eng_raddr), .done(done), .prog_fail(prog_fail)
  );

  assign mem_raddr = busy ? eng_raddr : bus_addr[IDX_W:1];

  flc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q <= 1'b0; per_q <= 1'b0; mer_q <= 1'b0; strt_q <= 1'b0;
      addr_q <= '0;
      pgerr_q <= 1'b0; lkerr_q <= 1'b0; eop_q <= 1'b0;
    end else begin
      if (open_ctrl) begin
        pg_q  <= bus_wdata[C_PG];
        per_q <= bus_wdata[C_PER];
        mer_q <= bus_wdata[C_MER];
      end
      if (start_erase) strt_q <= 1'b1;
      else if (done)   strt_q <= 1'b0;
      if (bus_we && hit_addr && !busy && !locked) addr_q <= bus_wdata[AR_W-1:0];
      eop_q   <= done      || (eop_q   && !(bus_we && hit_stat && bus_wdata[S_EOP]));
      pgerr_q <= prog_fail || (pgerr_q && !(bus_we && hit_stat && bus_wdata[S_PGERR]));
      lkerr_q <= lock_err  || (lkerr_q && !(bus_we && hit_stat && bus_wdata[S_LKERR]));
    end
  end

  always_comb begin
    reg_mux = 32'h0;
    if (hit_stat)      reg_mux = {26'h0, eop_q, lkerr_q, 1'b0, pgerr_q, 1'b0, busy};
    else if (hit_ctrl) reg_mux = {24'h0, locked, strt_q, 3'b000, mer_q, per_q, pg_q};
    else if (hit_addr) reg_mux = {{(32-AR_W){1'b0}}, addr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_flash_q <= 1'b0;
      reg_q      <= 32'h0;
    end else begin
      rd_flash_q <= bus_re && is_flash && !busy;
      reg_q      <= (bus_re && !is_flash) ? reg_mux : 32'h0;
    end
  end

  assign bus_rdata = rd_flash_q ? {16'h0, mem_q} : reg_q;
endmodule

// File: rtl/flc_regs_chk.sv
module flc_regs_chk
  import flc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AR_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              locked,
  input logic              dead,
  input logic              busy,
  input logic              eop_q,
  input logic              strt_q,
  input logic              lkerr_q,
  input logic              pg_q,
  input logic [AR_W-1:0]   addr_q
);
  localparam logic [ADDR_W-1:0] KEY_A = {1'b0, OFS_KEY[ADDR_W-2:0]};

  // R2
  unlock_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(bus_we && bus_addr == KEY_A && bus_wdata == KEY_SECOND));

  // R3
  dead_is_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dead |=> dead && locked);

  // R4
  locked_regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(pg_q) && $stable(addr_q));

  // R5
  strt_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !strt_q);

  // R7
  eop_at_busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eop_q) |-> $fell(busy));

  // R9
  locked_flash_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[ADDR_W-1] && locked && !busy) |=> lkerr_q);

  // R11
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));
endmodule

bind flc_regs flc_regs_chk #(.ADDR_W(ADDR_W), .AR_W(AR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .locked(locked), .dead(dead), .busy(busy), .eop_q(eop_q), .strt_q(strt_q),
  .lkerr_q(lkerr_q), .pg_q(pg_q), .addr_q(addr_q)
);

// File: tb/flc_regs_test.sv
module flc_regs_test;
  localparam int PROG_WAIT = 3;
  localparam int DEPTH     = 64;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;
  localparam logic [7:0] A_KEY = 8'h04, A_ST = 8'h0C, A_CT = 8'h10, A_AD = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_re = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int    tests = 0, fails = 0;
  bit    finished = 0;
  string cur_req = "R1";

  flc_regs uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_re(bus_re), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int          lk;            // 0 open, 1 wait first key, 2 wait second key, 3 dead
  bit          m_pg, m_per, m_mer, m_strt, m_e2, m_e4, m_eop;
  int          busy_left, op_kind, op_page, p_idx;
  bit          p_ok;
  logic [15:0] p_dat;
  logic [6:0]  areg;
  logic [15:0] mmem [DEPTH];
  logic [31:0] exp_rd = '0;

  initial for (int i = 0; i < DEPTH; i++) mmem[i] = 16'hFFFF;

  always @(posedge clk) begin
    if (rst) begin
      lk = 1; m_pg = 0; m_per = 0; m_mer = 0; m_strt = 0;
      m_e2 = 0; m_e4 = 0; m_eop = 0; busy_left = 0; areg = '0; exp_rd = '0;
    end else begin
      bit          bz;
      int          start_len;
      logic [31:0] nexp;
      bz = (busy_left > 0);
      start_len = 0;
      nexp = '0;
      if (bus_re) begin
        if (bus_addr[7]) nexp = bz ? 32'h0 : {16'h0, mmem[bus_addr[6:1]]};
        else if (bus_addr == A_ST) nexp = {26'h0, m_eop, m_e4, 1'b0, m_e2, 1'b0, bz};
        else if (bus_addr == A_CT) nexp = {24'h0, (lk != 0), m_strt, 3'b0, m_mer, m_per, m_pg};
        else if (bus_addr == A_AD) nexp = {25'h0, areg};
      end
      if (bus_we) begin
        if (bus_addr[7]) begin
          if (!bz) begin
            if (lk != 0) m_e4 = 1;
            else if (m_pg) begin
              p_idx = int'(bus_addr[6:1]); p_dat = bus_wdata[15:0];
              p_ok = (mmem[p_idx] == 16'hFFFF);
              op_kind = 2; start_len = p_ok ? 2 + PROG_WAIT : 2;
            end
          end
        end else if (bus_addr == A_KEY) begin
          if (lk == 1) lk = (bus_wdata == K1) ? 2 : 3;
          else if (lk == 2) lk = (bus_wdata == K2) ? 0 : 3;
        end else if (bus_addr == A_ST) begin
          if (bus_wdata[2]) m_e2 = 0;
          if (bus_wdata[4]) m_e4 = 0;
          if (bus_wdata[5]) m_eop = 0;
        end else if (bus_addr == A_CT && !bz) begin
          if (lk != 0) begin
            if (bus_wdata[6] && (bus_wdata[1] || bus_wdata[2])) m_e4 = 1;
            if (bus_wdata[7] && lk != 3) lk = 1;
          end else begin
            m_pg = bus_wdata[0]; m_per = bus_wdata[1]; m_mer = bus_wdata[2];
            if (bus_wdata[7]) lk = 1;
            if (bus_wdata[6] && (bus_wdata[1] || bus_wdata[2])) begin
              m_strt = 1;
              op_kind = bus_wdata[2] ? 1 : 0;
              op_page = int'(areg[6:5]);
              start_len = bus_wdata[2] ? 64 : 16;
            end
          end
        end else if (bus_addr == A_AD && !bz && lk == 0) begin
          areg = bus_wdata[6:0];
        end
      end
      if (bz) begin
        busy_left--;
        if (busy_left == 0) begin
          if (op_kind == 2) begin
            if (p_ok) begin mmem[p_idx] = p_dat; m_eop = 1; end
            else m_e2 = 1;
          end else begin
            for (int j = 0; j < DEPTH; j++)
              if (op_kind == 1 || (j / 16) == op_page) mmem[j] = 16'hFFFF;
            m_eop = 1;
          end
          m_strt = 0;
        end
      end
      if (start_len > 0) busy_left = start_len;
      exp_rd = nexp;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      tests++;
      if (bus_rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s: bus_rdata=%h expected=%h at %0t", cur_req, bus_rdata, exp_rd, $time);
      end
    end
  end

  task automatic put(input bit re, input bit we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_re = re; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); put(0, 1, a, d); endtask
  task automatic rd(input logic [7:0] a); put(1, 0, a, '0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) put(0, 0, '0, '0); endtask
  function automatic logic [7:0] fa(input int idx); return 8'h80 | 8'(idx << 1); endfunction
  task automatic poll_status(input int n); for (int i = 0; i < n; i++) rd(A_ST); endtask
  task automatic unlock(); wr(A_KEY, K1); wr(A_KEY, K2); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    rd(A_CT); rd(A_ST); rd(A_AD); rd(fa(0)); rd(fa(63)); idle(1);
    cur_req = "R12";
    rd(8'h00); rd(A_KEY); rd(8'h1C); rd(8'h20); idle(2);
    cur_req = "R4";
    wr(A_CT, 32'h1); rd(A_CT); wr(A_AD, 32'h26); rd(A_AD); idle(1);
    cur_req = "R9";
    wr(fa(3), 32'h0000_1111); rd(A_ST); rd(fa(3));
    cur_req = "R10";
    wr(A_ST, 32'h10); rd(A_ST);
    cur_req = "R9";
    wr(A_CT, 32'h42); rd(A_ST); rd(A_CT); wr(A_ST, 32'h34); rd(A_ST);
    cur_req = "R2";
    unlock(); rd(A_CT); idle(1);
    cur_req = "R7";
    wr(A_CT, 32'h1); rd(A_CT);
    wr(fa(5), 32'hABCD_1234); poll_status(7); rd(fa(5));
    cur_req = "R11";
    wr(fa(6), 32'h0000_5555); rd(fa(5)); wr(fa(7), 32'h0000_7777); wr(A_AD, 32'h7F);
    wr(A_CT, 32'h0); rd(A_AD); rd(A_CT); poll_status(3); rd(fa(7)); rd(fa(6));
    cur_req = "R8";
    wr(fa(5), 32'h0000_0000); poll_status(4); rd(fa(5));
    cur_req = "R10";
    wr(A_ST, 32'h24); rd(A_ST);
    cur_req = "R7";
    for (int k = 16; k < 40; k += 7) begin
      wr(fa(k), 32'(16'h1000 + k)); idle(5);
    end
    rd(fa(16)); rd(fa(23)); rd(fa(30)); rd(fa(37));
    cur_req = "R5";
    wr(A_AD, 32'h26); rd(A_AD);
    wr(A_CT, 32'h42); rd(A_CT); poll_status(17); rd(A_CT);
    rd(fa(16)); rd(fa(23)); rd(fa(30)); rd(fa(37)); rd(fa(6));
    cur_req = "R10";
    wr(A_ST, 32'h20); rd(A_ST);
    cur_req = "R6";
    wr(A_CT, 32'h1); wr(fa(40), 32'h0000_4242); idle(6);
    wr(fa(63), 32'h0000_6363); idle(6); rd(fa(40)); rd(fa(63));
    wr(A_CT, 32'h46); poll_status(66); rd(fa(40)); rd(fa(63)); rd(fa(6)); rd(A_CT);
    cur_req = "R4";
    wr(A_CT, 32'h81); rd(A_CT); wr(A_CT, 32'h02); rd(A_CT);
    cur_req = "R3";
    wr(A_KEY, K2); rd(A_CT); unlock(); rd(A_CT); wr(A_CT, 32'h80); unlock(); rd(A_CT);
    idle(2);
    rst = 1'b1; idle(2); rst = 1'b0;
    cur_req = "R1";
    rd(A_CT); rd(A_ST); rd(fa(63));
    cur_req = "R3";
    wr(A_KEY, K1); wr(A_KEY, 32'h1234_5678); rd(A_CT); unlock(); rd(A_CT);
    wr(A_AD, 32'h11); rd(A_AD);
    rst = 1'b1; idle(2); rst = 1'b0;
    cur_req = "R2";
    unlock(); rd(A_CT); wr(A_AD, 32'h11); rd(A_AD);
    cur_req = "R10";
    wr(A_CT, 32'h1); wr(fa(9), 32'h9);
    idle(4); wr(A_ST, 32'h20); rd(A_ST); idle(2);
    idle(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule